// File: doc/BRIEF.md
# Two-stage 16x baud tick generator

This block turns one reference clock into a clock-enable pulse at sixteen times a chosen baud rate. A coarse prescaler divides the reference by 1, 3, 4 or 5. A divisor stage follows it and divides by an integer or by a fractional average, or it can be bypassed. The three common reference frequencies of 1.8432, 2.4576 and 3.072 MHz, divided by 3, 4 and 5 respectively, all give 614.4 kHz at the prescaler output. From that rate the divisor stage reaches the standard rates from 38.4k down to 50 baud.

An 8-bit select word programs the divider. It is loaded on a one-cycle write strobe, and every load restarts both counters. A second output, `clk_out`, carries either the reference clock or a square version of the generated 16x clock. The transmit and receive logic uses `tick` as its sampling enable.

Top module: `baud_tick_gen`

## Requirements
- R1: Bits [1:0] of the select word choose the prescale ratio: code 0 gives ÷1, code 1 gives ÷3, code 2 gives ÷4 and code 3 gives ÷5.
- R2: Bits [6:2] hold the divisor code. Integer codes are 1=2, 2=4, 4=8, 6=16, 8=22, 9=32, 10=64, 11=128, 12=192, 13=256, 14=288, 15=352, 16=512 and 17=768. The tick period is the prescale ratio times the divisor, in reference cycles.
- R3: Fractional codes repeat a three-period pattern, counted in prescaler pulses and starting at the load: code 3 (16/3) uses 5,5,6, code 5 (32/3) uses 11,11,10, and code 7 (58/3) uses 19,19,20.
- R4: Divisor code 0 and the unused codes 18 to 31 bypass the divisor stage, so a tick comes every prescale period. With ÷1 this means a tick on every cycle.
- R5: `tick` is high for exactly one cycle per period, except when ÷1 is combined with the bypass.
- R6: A write restarts the division. `tick` is first high in the cycle that follows the rising edge one full new period after the write edge.
- R7: With bit 7 clear, `clk_out` carries the reference clock.
- R8: With bit 7 set, `clk_out` is the generated clock. It is high for the first floor(D/2) prescaler units of every period, where D is that period's divisor, and for floor(P/2) of P cycles when the divisor is bypassed. When ÷1 is combined with the bypass, `clk_out` carries the reference clock.
- R9: Reset clears the counters and bit 7 and drives `tick` low. It keeps the prescale and divisor codes, so after reset the division restarts exactly as after a write.
- R10: In the cycle right after a write edge, `tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_wr | input | 1 | One-cycle load strobe for the select word |
| sel_din | input | 8 | Select word: {clock-out select, divisor code[4:0], prescale code[1:0]} |
| tick | output | 1 | Registered 16x-baud enable pulse |
| clk_out | output | 1 | Reference clock or generated 16x clock |

## Verification
Every result comes out of a register that is loaded on the edge ending the last reference cycle of a period. A tick for a period of T cycles after a write at edge W is therefore visible only after edge W+T. The bench counts falling edges from the write edge and expects the first three ticks at exact counts. It also expects `tick` low at the falling edge right after the write or reset edge. The duty of the generated clock is checked by counting high falling-edge samples of `clk_out` from the second tick up to the sample before the third, a window that spans one whole period. The pass-through cases are checked by sampling a quarter period after a rising edge as well as at the falling edge.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  localparam int SEL_W    = 8;
  localparam int PS_W     = 2;
  localparam int CODE_W   = 5;
  localparam int PRE_W    = 3;   // holds ratios up to 5
  localparam int DIV_W    = 10;  // holds divisors up to 768
  localparam int PHASE_W  = 2;
  localparam int LAST_CODE = 17; // highest code with a real divisor

  typedef enum logic [PS_W-1:0] {
    PS_BY1 = 2'd0,
    PS_BY3 = 2'd1,
    PS_BY4 = 2'd2,
    PS_BY5 = 2'd3
  } ps_code_e;

  function automatic logic [PRE_W-1:0] ps_ratio(input logic [PS_W-1:0] code);
    case (ps_code_e'(code))
      PS_BY1:  return PRE_W'(1);
      PS_BY3:  return PRE_W'(3);
      PS_BY4:  return PRE_W'(4);
      default: return PRE_W'(5);
    endcase
  endfunction

  function automatic logic is_bypass(input logic [CODE_W-1:0] code);
    return (code == '0) || (int'(code) > LAST_CODE);
  endfunction

  function automatic logic is_frac(input logic [CODE_W-1:0] code);
    return (code == CODE_W'(3)) || (code == CODE_W'(5)) || (code == CODE_W'(7));
  endfunction

  // Period in prescaler pulses for a code and, for fractional codes, the phase.
  function automatic logic [DIV_W-1:0] div_period(input logic [CODE_W-1:0] code,
                                                  input logic [PHASE_W-1:0] ph);
    case (code)
      5'd1:    return DIV_W'(2);
      5'd2:    return DIV_W'(4);
      5'd3:    return (ph == 2'd2) ? DIV_W'(6)  : DIV_W'(5);
      5'd4:    return DIV_W'(8);
      5'd5:    return (ph == 2'd2) ? DIV_W'(10) : DIV_W'(11);
      5'd6:    return DIV_W'(16);
      5'd7:    return (ph == 2'd2) ? DIV_W'(20) : DIV_W'(19);
      5'd8:    return DIV_W'(22);
      5'd9:    return DIV_W'(32);
      5'd10:   return DIV_W'(64);
      5'd11:   return DIV_W'(128);
      5'd12:   return DIV_W'(192);
      5'd13:   return DIV_W'(256);
      5'd14:   return DIV_W'(288);
      5'd15:   return DIV_W'(352);
      5'd16:   return DIV_W'(512);
      5'd17:   return DIV_W'(768);
      default: return DIV_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/bg_cfg_reg.sv
module bg_cfg_reg
  import baud_gen_pkg::*;
#(
  parameter int W   = SEL_W,
  parameter int PSW = PS_W,
  parameter int CW  = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [W-1:0]  din,
  output logic [PSW-1:0] ps_code,
  output logic [CW-1:0]  div_code,
  output logic           co_sel
);

  localparam int DIV_LO = PSW;
  localparam int DIV_HI = PSW + CW - 1;
  localparam int CO_BIT = W - 1;

  logic [PSW-1:0] ps_q  = '0;
  logic [CW-1:0]  div_q = '0;
  logic           co_q;

  // Codes survive reset; only the clock-out select is cleared.
  always_ff @(posedge clk) begin
    if (wr) begin
      ps_q  <= din[PSW-1:0];
      div_q <= din[DIV_HI:DIV_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     co_q <= 1'b0;
    else if (wr) co_q <= din[CO_BIT];
  end

  assign ps_code  = ps_q;
  assign div_code = div_q;
  assign co_sel   = co_q;

endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int W = baud_gen_pkg::PRE_W
) (
  input  logic         clk,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  output logic         pre_en,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);

  logic [W-1:0] cnt_q = '0;

  always_comb begin
    pre_en = (cnt_q == ratio - W'(1));
    if (restart)     cnt_nxt = '0;
    else if (pre_en) cnt_nxt = '0;
    else             cnt_nxt = cnt_q + W'(1);
  end

  always_ff @(posedge clk) cnt_q <= cnt_nxt;

  assign cnt = cnt_q;

endmodule

// File: rtl/bg_divsel.sv
module bg_divsel
  import baud_gen_pkg::*;
#(
  parameter int W  = DIV_W,
  parameter int CW = CODE_W,
  parameter int PW = PHASE_W
) (
  input  logic          clk,
  input  logic          restart,
  input  logic          pre_en,
  input  logic [CW-1:0] code,
  output logic          bypass,
  output logic          frac,
  output logic          tick_nxt,
  output logic          lvl_nxt,
  output logic [W-1:0]  cnt,
  output logic [W-1:0]  period,
  output logic [PW-1:0] phase
);

  logic [W-1:0]  cnt_q = '0;
  logic [PW-1:0] ph_q  = '0;
  logic [W-1:0]  cnt_d, per_cur, per_nxt;
  logic [PW-1:0] ph_d;
  logic          at_last;

  always_comb begin
    bypass  = is_bypass(code);
    frac    = is_frac(code);
    per_cur = W'(div_period(code, ph_q));
    at_last = (cnt_q == per_cur - W'(1));
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    if (restart) begin
      cnt_d = '0;
      ph_d  = '0;
    end else if (pre_en && !bypass) begin
      if (at_last) begin
        cnt_d = '0;
        if (frac) ph_d = (ph_q == PW'(2)) ? '0 : ph_q + PW'(1);
        else      ph_d = '0;
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end
    per_nxt  = W'(div_period(code, ph_d));
    tick_nxt = pre_en && (bypass || at_last);
    lvl_nxt  = cnt_d < (per_nxt >> 1);
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
    ph_q  <= ph_d;
  end

  assign cnt    = cnt_q;
  assign period = per_cur;
  assign phase  = ph_q;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
#(
  parameter int SELW = SEL_W,
  parameter int PREW = PRE_W,
  parameter int DIVW = DIV_W,
  parameter int CODEW = CODE_W,
  parameter int PHW  = PHASE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_wr,
  input  logic [SELW-1:0] sel_din,
  output logic            tick,
  output logic            clk_out
);

  logic [PS_W-1:0]  ps_code;
  logic [CODEW-1:0] div_code;
  logic             co_sel;
  logic             restart;
  logic [PREW-1:0]  ratio, pre_cnt, pre_nxt;
  logic             pre_en;
  logic             bypass, frac, tick_nxt, lvl_div, pass_clk;
  logic [DIVW-1:0]  div_cnt, div_per;
  logic [PHW-1:0]   phase;
  logic             tick_q, gen_q;

  assign restart = rst | sel_wr;
  assign ratio   = ps_ratio(ps_code);

  bg_cfg_reg #(.W(SELW), .PSW(PS_W), .CW(CODEW)) u_cfg (
    .clk(clk), .rst(rst), .wr(sel_wr), .din(sel_din),
    .ps_code(ps_code), .div_code(div_code), .co_sel(co_sel)
  );

  bg_prescaler #(.W(PREW)) u_pre (
    .clk(clk), .restart(restart), .ratio(ratio),
    .pre_en(pre_en), .cnt(pre_cnt), .cnt_nxt(pre_nxt)
  );

  bg_divsel #(.W(DIVW), .CW(CODEW), .PW(PHW)) u_div (
    .clk(clk), .restart(restart), .pre_en(pre_en), .code(div_code),
    .bypass(bypass), .frac(frac), .tick_nxt(tick_nxt), .lvl_nxt(lvl_div),
    .cnt(div_cnt), .period(div_per), .phase(phase)
  );

  always_ff @(posedge clk) begin
    if (restart) begin
      tick_q <= 1'b0;
      gen_q  <= 1'b1;
    end else begin
      tick_q <= tick_nxt;
      gen_q  <= bypass ? (pre_nxt < (ratio >> 1)) : lvl_div;
    end
  end

  assign pass_clk = bypass && (ps_code == PS_W'(PS_BY1));
  assign tick     = tick_q;
  assign clk_out  = (!co_sel || pass_clk) ? clk : gen_q;

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int PREW = baud_gen_pkg::PRE_W,
  parameter int DIVW = baud_gen_pkg::DIV_W,
  parameter int PHW  = baud_gen_pkg::PHASE_W
) (
  input logic            clk,
  input logic            rst,
  input logic            sel_wr,
  input logic            tick,
  input logic            co_sel,
  input logic            pass_clk,
  input logic            frac,
  input logic [PREW-1:0] pre_cnt,
  input logic [PREW-1:0] ratio,
  input logic [DIVW-1:0] div_cnt,
  input logic [DIVW-1:0] div_per,
  input logic [PHW-1:0]  phase
);

  // R1
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pre_cnt < ratio);

  // R2
  div_bound_chk: assert property (@(posedge clk) disable iff (rst)
    div_cnt < div_per);

  // R3
  phase_frac_chk: assert property (@(posedge clk) disable iff (rst)
    (phase <= PHW'(2)) && (frac || phase == '0));

  // R5
  tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !pass_clk) |=> !tick);

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!tick && !co_sel && pre_cnt == '0 && div_cnt == '0));

  // R10
  wr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (!tick && pre_cnt == '0 && div_cnt == '0 && phase == '0));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.PREW(PREW), .DIVW(DIVW), .PHW(PHW)) u_chk (
  .clk(clk), .rst(rst), .sel_wr(sel_wr), .tick(tick), .co_sel(co_sel),
  .pass_clk(pass_clk), .frac(frac), .pre_cnt(pre_cnt), .ratio(ratio),
  .div_cnt(div_cnt), .div_per(div_per), .phase(phase)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  localparam int PER   = 10;
  localparam int WD    = 190000;
  localparam int LIMIT = 5000;
  localparam int NV    = 14;

  // {clock-out select, divisor code, prescale code} and expected results
  localparam logic [7:0] V_CFG [NV] = '{8'h85, 8'h8E, 8'h94, 8'h9F, 8'h00, 8'h81, 8'hA0,
                                        8'h0B, 8'hC4, 8'hD2, 8'h32, 8'hB8, 8'h83, 8'hC1};
  localparam int V_I1 [NV] = '{6, 20, 11, 95, 1, 3, 22, 20, 768, 4, 768, 288, 5, 1536};
  localparam int V_I2 [NV] = '{6, 20, 11, 95, 1, 3, 22, 20, 768, 4, 768, 288, 5, 1536};
  localparam int V_I3 [NV] = '{6, 24, 10, 100, 1, 3, 22, 20, 768, 4, 768, 288, 5, 1536};
  localparam int V_HI [NV] = '{3, 12, 5, 50, 0, 1, 11, 0, 384, 2, 0, 144, 2, 768};
  localparam string V_REQ [NV] = '{"R2", "R3", "R3", "R3", "R4", "R4", "R2",
                                   "R1", "R2", "R4", "R1", "R2", "R4", "R2"};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_wr = 1'b0;
  logic [7:0] sel_din = '0;
  logic       tick, clk_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  baud_tick_gen uut (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_din(sel_din),
    .tick(tick), .clk_out(clk_out)
  );

  always #(PER/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the falling edge right after a write or reset edge (sample 0).
  task automatic measure(output int t1, output int t2, output int t3, output int hi);
    int k = 0;
    int found = 0;
    t1 = 0; t2 = 0; t3 = 0; hi = 0;
    while (found < 3 && k < LIMIT) begin
      @(negedge clk);
      k++;
      if (tick) begin
        found++;
        if (found == 1) t1 = k;
        if (found == 2) t2 = k;
        if (found == 3) t3 = k;
      end
      if (found == 2) hi += int'(clk_out);
    end
  endtask

  task automatic load(input logic [7:0] c);
    @(negedge clk);
    sel_din = c;
    sel_wr  = 1'b1;
    @(negedge clk);
    sel_wr  = 1'b0;
  endtask

  initial begin
    int t1, t2, t3, hi;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 tick low in reset", int'(tick), 0);
    @(posedge clk); #(PER/4);
    check("R7 clk_out follows clock in reset", int'(clk_out), 1);
    @(negedge clk);
    check("R7 clk_out low phase", int'(clk_out), 0);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      load(V_CFG[i]);
      check("R10 tick low after write", int'(tick), 0);
      measure(t1, t2, t3, hi);
      check({V_REQ[i], " R6 first tick"}, t1, V_I1[i]);
      check({V_REQ[i], " second interval"}, t2 - t1, V_I2[i]);
      check({V_REQ[i], " third interval"}, t3 - t2, V_I3[i]);
      check(V_CFG[i][7] ? "R8 duty count" : "R7 clock-out samples", hi, V_HI[i]);
    end

    // R8: ÷1 with bypass and clock-out select passes the clock through
    load(8'h80);
    @(posedge clk); #(PER/4);
    check("R8 passthrough high phase", int'(clk_out), 1);
    check("R5 continuous tick", int'(tick), 1);
    @(negedge clk);
    check("R8 passthrough low phase", int'(clk_out), 0);

    // R9: reset keeps codes, clears clock-out select
    load(8'h85);
    repeat (17) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 tick low after reset", int'(tick), 0);
    measure(t1, t2, t3, hi);
    check("R9 divisor kept, first tick", t1, 6);
    check("R9 divisor kept, interval", t3 - t2, 6);
    check("R9 clock-out select cleared", hi, 0);

    // R6: mid-period rewrite restarts the count
    load(8'h44);
    repeat (100) @(negedge clk);
    load(8'h04);
    check("R10 tick low after rewrite", int'(tick), 0);
    measure(t1, t2, t3, hi);
    check("R6 restart first tick", t1, 2);
    check("R5 pulse spacing", t2 - t1, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule